// File: doc/BRIEF.md
# Receive descriptor ring writer

This block moves received frames from a byte stream into memory buffers described by a circular list of descriptors. Each descriptor is two 32-bit words. The address word carries a word-aligned buffer pointer in bits 31:2, a wrap marker in bit 1 and an ownership bit in bit 0. The status word, 4 bytes further on, is filled in by the block after it has used the buffer.

When a frame starts, the block reads the current address word. If software still holds the descriptor, the block drops the whole frame and flags a missing buffer. If the descriptor is free, it packs the bytes into little-endian words and writes them into the buffer. It then writes the status word and rewrites the address word with the ownership bit set. After that it steps to the next descriptor, or returns to the ring base when the wrap marker is set. A frame longer than one buffer continues into the following descriptors.

The memory port accepts one request per cycle. Read data returns one cycle after the request is seen. The ring base is an input that the block samples whenever receive is switched on.

Top module: `rx_ring_writer`

## Requirements
- R1: At the start of a frame, the block reads the address word at the ring pointer. It fills the buffer only when bit 0 of that word is 0. Bits 31:2 give the buffer byte address divided by 4.
- R2: Frame bytes are written in arrival order starting at the buffer address. Byte n of a buffer goes to lane n mod 4 (bits 8*(n mod 4)+7 down to 8*(n mod 4)) of word n/4. Only the lanes that received bytes are enabled. Every memory address is a multiple of 4.
- R3: If bit 0 of the fetched address word is 1, no byte of the frame is written and no descriptor word is changed. The `nobuf` output pulses high for exactly one cycle. The ring pointer does not move, so the next frame tries the same descriptor again.
- R4: The status word holds the length in bits 13:0, a start-of-frame flag in bit 14 and an end-of-frame flag in bit 15. All other bits are 0.
- R5: After filling a buffer, the block writes the status word at pointer+4. It then rewrites the address word with bit 0 set, and with the buffer address and wrap bit unchanged.
- R6: A frame longer than BUF_BYTES fills each buffer to BUF_BYTES and then continues into the next descriptor. Only the first descriptor carries the start flag and only the last carries the end flag. Intermediate descriptors report BUF_BYTES as their length, and the last reports the total frame length.
- R7: After a descriptor is handed back, the pointer advances by 8 bytes. If the descriptor's bit 1 was set, the pointer returns to the ring base instead.
- R8: Each time `rx_en` goes from 0 to 1, the ring pointer is reloaded from `ring_base`.
- R9: While `rx_en` is 0 and no frame is in progress, incoming bytes are accepted and discarded without any memory request.
- R10: After reset, `mem_req` and `nobuf` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable; a rising edge reloads the ring pointer |
| ring_base | input | 32 | Byte address of the first descriptor |
| in_valid | input | 1 | A byte is present on the stream |
| in_sof | input | 1 | The present byte is the first of a frame |
| in_eof | input | 1 | The present byte is the last of a frame |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | The block takes the present byte at this clock edge |
| mem_req | output | 1 | Memory request, accepted in the same cycle |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read request |
| nobuf | output | 1 | One-cycle pulse when a frame is dropped for want of a free descriptor |

## Verification
A ring pointer that is off by one descriptor, or that misses the wrap, shows up on the very next frame. The address word of the wrong descriptor gains its ownership bit, while the expected descriptor stays free. A packing or lane error shows up as a wrong byte in the buffer as soon as the word holding it is written. A wrong length or flag is visible in the status word right after the last byte of each buffer. A missed ownership test shows up within the same frame, either as buffer writes to a software-held descriptor or as a missing `nobuf` pulse.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_FETCH, ST_WREQ, ST_WDESC, ST_RECV,
    ST_WDATA, ST_WSTAT, ST_WOWN, ST_DROP
  } rxr_state_e;

  localparam int DESC_BYTES = 8;
  localparam int OWN_BIT    = 0;
  localparam int WRAP_BIT   = 1;
  localparam int LEN_W      = 14;
  localparam int SOF_BIT    = 14;
  localparam int EOF_BIT    = 15;
endpackage

// File: rtl/rx_word_pack.sv
module rx_word_pack #(
  parameter int LANES = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     take,
  input  logic [7:0]               din,
  output logic [8*LANES-1:0]       word,
  output logic [LANES-1:0]         be,
  output logic [$clog2(LANES)-1:0] lane
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      word <= '0;
      be   <= '0;
      lane <= '0;
    end else if (take) begin
      word[8*lane +: 8] <= din;
      be[lane]          <= 1'b1;
      lane              <= lane + 1'b1;
    end
  end
endmodule

// File: rtl/rx_ring_ptr.sv
module rx_ring_ptr #(
  parameter int AW   = 32,
  parameter int STEP = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reload,
  input  logic          advance,
  input  logic          wrap,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst)
      ptr <= '0;
    else if (reload)
      ptr <= base;
    else if (advance)
      ptr <= wrap ? base : ptr + AW'(STEP);
  end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxr_pkg::*;
#(
  parameter int BUF_BYTES = 1536
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_en,
  input  logic [31:0] ring_base,
  input  logic        in_valid,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        nobuf
);
  localparam int CNT_W = $clog2(BUF_BYTES + 1);
  localparam logic [CNT_W-1:0] BUF_LIM = CNT_W'(BUF_BYTES);

  rxr_state_e       state;
  logic             rx_en_q;
  logic [31:0]      ptr;
  logic [29:0]      buf_addr;
  logic             wrap_q;
  logic [31:0]      wr_addr;
  logic [CNT_W-1:0] buf_cnt;
  logic [LEN_W-1:0] frm_len;
  logic             sof_pend, eof_seen, buf_done;
  logic [31:0]      pk_word;
  logic [3:0]       pk_be;
  logic [1:0]       pk_lane;

  logic take, reload, pk_take, pk_clr, last_in_buf;
  logic [CNT_W-1:0] buf_cnt_nx;
  logic [LEN_W-1:0] stat_len;

  always_comb begin
    case (state)
      ST_IDLE:          in_ready = !rx_en || !in_sof;
      ST_RECV, ST_DROP: in_ready = 1'b1;
      default:          in_ready = 1'b0;
    endcase
  end

  assign take        = in_valid && in_ready;
  assign reload      = rx_en && !rx_en_q;
  assign pk_take     = (state == ST_RECV) && take;
  assign pk_clr      = (state == ST_WDATA) || (state == ST_WDESC);
  assign buf_cnt_nx  = buf_cnt + 1'b1;
  assign last_in_buf = (buf_cnt_nx == BUF_LIM);
  assign stat_len    = eof_seen ? frm_len : LEN_W'(buf_cnt);

  rx_word_pack #(.LANES(4)) u_pack (
    .clk(clk), .rst(rst), .clr(pk_clr), .take(pk_take), .din(in_data),
    .word(pk_word), .be(pk_be), .lane(pk_lane)
  );

  rx_ring_ptr #(.AW(32), .STEP(DESC_BYTES)) u_ptr (
    .clk(clk), .rst(rst), .reload(reload), .advance(state == ST_WOWN),
    .wrap(wrap_q), .base(ring_base), .ptr(ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;   rx_en_q <= 1'b0;
      mem_req <= 1'b0;    mem_we <= 1'b0;   mem_addr <= '0;
      mem_be <= '0;       mem_wdata <= '0;  nobuf <= 1'b0;
      buf_addr <= '0;     wrap_q <= 1'b0;   wr_addr <= '0;
      buf_cnt <= '0;      frm_len <= '0;
      sof_pend <= 1'b0;   eof_seen <= 1'b0; buf_done <= 1'b0;
    end else begin
      rx_en_q <= rx_en;
      mem_req <= 1'b0;
      mem_we  <= 1'b0;
      nobuf   <= 1'b0;
      case (state)
        ST_IDLE: if (rx_en && in_valid && in_sof) begin
          sof_pend <= 1'b1;
          frm_len  <= '0;
          state    <= ST_FETCH;
        end
        ST_FETCH: begin
          mem_req  <= 1'b1;
          mem_addr <= ptr;
          mem_be   <= 4'hF;
          state    <= ST_WREQ;
        end
        ST_WREQ: state <= ST_WDESC;
        ST_WDESC: begin
          if (mem_rdata[OWN_BIT]) begin
            nobuf <= 1'b1;
            state <= ST_DROP;
          end else begin
            buf_addr <= mem_rdata[31:2];
            wrap_q   <= mem_rdata[WRAP_BIT];
            wr_addr  <= {mem_rdata[31:2], 2'b00};
            buf_cnt  <= '0;
            state    <= ST_RECV;
          end
        end
        ST_RECV: if (take) begin
          buf_cnt <= buf_cnt_nx;
          frm_len <= frm_len + 1'b1;
          if (pk_lane == 2'd3 || in_eof || last_in_buf) begin
            eof_seen <= in_eof;
            buf_done <= in_eof || last_in_buf;
            state    <= ST_WDATA;
          end
        end
        ST_WDATA: begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= wr_addr;
          mem_wdata <= pk_word;
          mem_be    <= pk_be;
          wr_addr   <= wr_addr + 32'd4;
          state     <= buf_done ? ST_WSTAT : ST_RECV;
        end
        ST_WSTAT: begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= ptr + 32'd4;
          mem_be    <= 4'hF;
          mem_wdata <= {16'd0, eof_seen, sof_pend, stat_len};
          state     <= ST_WOWN;
        end
        ST_WOWN: begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= ptr;
          mem_be    <= 4'hF;
          mem_wdata <= {buf_addr, wrap_q, 1'b1};
          sof_pend  <= 1'b0;
          state     <= eof_seen ? ST_IDLE : ST_FETCH;
        end
        ST_DROP: if (take && in_eof) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_addr_align_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  assert_drop_owned_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(nobuf) |-> $past(mem_rdata[OWN_BIT]));

  assert_drop_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    nobuf |=> !nobuf);

  assert_buf_bound_R6: assert property (@(posedge clk) disable iff (rst)
    buf_cnt <= BUF_LIM);

  assert_reload_base_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_en) |=> (ptr == $past(ring_base)));
endmodule

// File: tb/sim_rx_ring_writer.sv
`timescale 1ns/1ps
module sim_rx_ring_writer;
  localparam int BUFB = 8;
  localparam int NDESC = 3;
  localparam int NF = 7;
  localparam int FLEN [NF] = '{1, 4, 5, 8, 9, 16, 24};
  localparam int NBUF [NF] = '{1, 1, 1, 1, 2, 2, 3};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_en = 1'b0;
  logic [31:0] ring_base = 32'h0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = 8'h0;
  logic in_ready, mem_req, mem_we, nobuf;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0] mem_be;

  logic [31:0] mem [64];
  int nchk = 0, nerr = 0, wr_cnt = 0, req_cnt = 0, nob_cnt = 0;
  int exp_idx = 0;

  always #2.5 clk = ~clk;

  rx_ring_writer #(.BUF_BYTES(BUFB)) u0 (
    .clk(clk), .rst(rst), .rx_en(rx_en), .ring_base(ring_base),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
    .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .nobuf(nobuf)
  );

  always @(posedge clk) begin
    if (!rst && nobuf) nob_cnt = nob_cnt + 1;
    if (!rst && mem_req) begin
      req_cnt = req_cnt + 1;
      if (mem_we) begin
        wr_cnt = wr_cnt + 1;
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[7:2]][8*b +: 8] = mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= mem[mem_addr[7:2]];
      end
    end
  end

  function automatic int buf_base(input int d);
    return 32'h40 + 32'h20 * d;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_frame(input int len, input logic [7:0] seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sof   = (i == 0);
      in_eof   = (i == len - 1);
      in_data  = seed + 8'(i);
      #1;
      while (!in_ready) begin
        @(negedge clk);
        #1;
      end
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    repeat (15) @(negedge clk);
  endtask

  // Checks the descriptors a frame used, then hands them back to the design.
  task automatic verify_frame(input int len, input logic [7:0] seed);
    int nb;
    nb = (len + BUFB - 1) / BUFB;
    for (int k = 0; k < nb; k++) begin
      int d, cnt;
      logic [31:0] st;
      d = exp_idx;
      cnt = (k == nb - 1) ? len - k * BUFB : BUFB;
      // R1, R5, R7: landing descriptor owned, address and wrap intact
      chk("R5 addr word", mem[2*d],
          buf_base(d) | ((d == NDESC - 1) ? 32'h2 : 32'h0) | 32'h1);
      st = {16'd0, (k == nb - 1), (k == 0), 14'((k == nb - 1) ? len : BUFB)};
      chk("R4 R6 status word", mem[2*d + 1], st);
      for (int j = 0; j < cnt; j++)
        chk("R2 data byte", 32'(mem[(buf_base(d) >> 2) + j / 4][8*(j % 4) +: 8]),
            32'(seed + 8'(k * BUFB + j)));
      mem[2*d][0] = 1'b0;
      mem[2*d + 1] = 32'h0;
      exp_idx = (d + 1) % NDESC;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    for (int w = 0; w < 64; w++) mem[w] = 32'h0;
    for (int d = 0; d < NDESC; d++)
      mem[2*d] = buf_base(d) | ((d == NDESC - 1) ? 32'h2 : 32'h0);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 mem_req after reset", 32'(mem_req), 32'd0);
    chk("R10 nobuf after reset", 32'(nobuf), 32'd0);

    // R9: disabled receive swallows a frame without memory traffic
    send_frame(6, 8'hA0);
    chk("R9 no requests while disabled", 32'(req_cnt), 32'd0);

    rx_en = 1'b1;
    @(negedge clk);
    for (int f = 0; f < NF; f++) begin
      int start, wr0;
      start = exp_idx;
      wr0 = wr_cnt;
      send_frame(FLEN[f], 8'(16 * f + 1));
      verify_frame(FLEN[f], 8'(16 * f + 1));
      chk("R7 ring index step", 32'(exp_idx), 32'((start + NBUF[f]) % NDESC));
      chk("R6 writes per frame", 32'(wr_cnt - wr0),
          32'((FLEN[f] + 3) / 4 + 2 * NBUF[f] + (NBUF[f] > 1 ? NBUF[f] - 1 : 0) * 0));
    end

    // R3: descriptor still held by software
    begin
      int wr0, nb0, d;
      d = exp_idx;
      mem[2*d][0] = 1'b1;
      mem[2*d + 1] = 32'h0000ABCD;
      wr0 = wr_cnt;
      nb0 = nob_cnt;
      send_frame(5, 8'h70);
      chk("R3 nobuf pulse count", 32'(nob_cnt - nb0), 32'd1);
      chk("R3 no writes on drop", 32'(wr_cnt - wr0), 32'd0);
      chk("R3 status untouched", mem[2*d + 1], 32'h0000ABCD);
      mem[2*d][0] = 1'b0;
      mem[2*d + 1] = 32'h0;
      send_frame(3, 8'h80);
      chk("R3 retry lands on same descriptor", 32'(mem[2*d][0]), 32'd1);
      verify_frame(3, 8'h80);
    end

    // R8: re-enable reloads pointer from base
    if (exp_idx == 0) begin
      send_frame(2, 8'h90);
      verify_frame(2, 8'h90);
    end
    @(negedge clk); rx_en = 1'b0;
    repeat (2) @(negedge clk);
    rx_en = 1'b1;
    @(negedge clk);
    exp_idx = 0;
    send_frame(6, 8'hC0);
    chk("R8 frame after re-enable at base", 32'(mem[0][0]), 32'd1);
    verify_frame(6, 8'hC0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule